// File: doc/BRIEF.md
# PCM B-Channel Serial Port

This block is the codec-side end of a time-multiplexed PCM frame bus. The bus carries a data clock that runs at twice the bit rate and a frame-sync pulse once per 125 µs frame. In each frame the port exchanges one byte in one 8-bit B channel: either the first channel (B1, bits 0 to 7 after the sync) or the second (B2, bits 8 to 15). The port shifts its transmit byte out MSB first on a data output that it drives only inside that channel. In the same channel it assembles the byte arriving on the serial input.

All bus inputs are brought into the system clock domain through synchronizers, and the frame position is tracked only by counting data-clock edges, so any bus clock between 512 kHz and 6176 kHz works. Edges are numbered from the frame-start edge (edge 0, a rising edge). PCM bit k of the frame covers edges 4k to 4k+3: rising, falling, rising, falling. The port only exchanges data once the spacing between frame syncs, measured in data-clock edges, has repeated. A sync that arrives off that spacing, that goes missing, or that is too short is treated as a loss of lock.

Top module: `pcm_bslot_port`

## Requirements
- R1: After reset the output enable `ser_oe_o` and `rx_valid_o` are 0.
- R2: A frame starts on the first data-clock rising edge at or after a frame-sync rise. If the frame sync rises while the data clock is already high, the frame starts at that sync rise. In the selected channel, the output enable goes to 1 at the start of the channel's MSB.
- R3: Each bit is held on `ser_out_o` for two data-clock periods (4 edges) and changes only at rising edges. The byte is sent MSB first.
- R4: `ser_oe_o` returns to 0 at the second falling edge of the LSB bit period (channel edge 31).
- R5: `slot_sel_i`=0 selects B1 (frame edges 0 to 31) and 1 selects B2 (frame edges 32 to 63). It is sampled at frame start, and transmit and receive both use that channel.
- R6: The serial input is sampled at the second falling edge of each bit of the channel. One `rx_valid_o` pulse, exactly one system-clock cycle long, follows the LSB and presents the byte MSB first.
- R7: The transmit byte is copied into the port at the start of the channel. If `tx_load_i` has not strobed since the previous copy, the previous byte is sent again.
- R8: A frame is exchanged only when its sync-to-sync spacing in data-clock edges equals the spacing measured for the previous frame. The first two syncs after reset therefore exchange nothing.
- R9: A sync that arrives early or late relative to the stored spacing, or a sync that is missing, stops all exchange until two consecutive spacings match again.
- R10: If the frame sync is already low at the first falling edge after the frame start, the frame is abandoned and no byte is exchanged.
- R11: Outside the active channel of a locked frame, `ser_oe_o` is 0 and no `rx_valid_o` pulse occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus data clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_clk_i | input | 1 | Bus data clock, asynchronous, twice the bit rate |
| frame_sync_i | input | 1 | Bus frame-sync pulse, asynchronous |
| ser_in_i | input | 1 | Serial receive data from the bus |
| slot_sel_i | input | 1 | Channel select: 0 = B1, 1 = B2 |
| tx_byte_i | input | 8 | Transmit byte |
| tx_load_i | input | 1 | Strobe that captures `tx_byte_i` |
| ser_out_o | output | 1 | Serial transmit data, meaningful while enabled |
| ser_oe_o | output | 1 | Drive enable for the tri-state bus output |
| rx_byte_o | output | 8 | Last received byte |
| rx_valid_o | output | 1 | One-cycle pulse when `rx_byte_o` is updated |

## Verification
The exchange is exercised in both channels with random bytes. Frames start both with the sync rising together with the data clock and with the sync rising inside the clock's high phase, which separates the two frame-start rules. Held transmit bytes (no load strobe) show whether the port resends or picks up stale input. Sync disturbances test the lock logic and the abandon rule: a glitch sync that drops before the first falling edge, a missing sync, an early sync, and changes of frame length. Each half-period sample compares both the enable and the data bit, which catches off-by-one errors in the channel window and at the release point.

// File: rtl/pcm_bslot_pkg.sv
// Shared definitions for the PCM B-channel serial port.
// Assumes a bit period of exactly two data-clock periods.
package pcm_bslot_pkg;
    // Data-clock edges (rise, fall, rise, fall) in one PCM bit.
    localparam int EDGES_PER_BIT = 4;

    // Channel select encoding.
    typedef enum logic {
        SLOT_B1 = 1'b0,
        SLOT_B2 = 1'b1
    } slot_e;
endpackage

// File: rtl/pcm_bslot_sync.sv
// Synchronizes the three asynchronous bus inputs into the system clock
// domain and produces single-cycle edge strobes for clock and sync.
// Assumes clk is at least about four times faster than the data clock.
module pcm_bslot_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_clk_i,
    input  logic frame_sync_i,
    input  logic ser_in_i,
    output logic dk_o,
    output logic fs_o,
    output logic din_o,
    output logic rise_dk_o,
    output logic fall_dk_o,
    output logic rise_fs_o
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [2:0] stage_q [SYNC_STAGES];
    logic       dk_q;
    logic       fs_q;

    // Shift the raw inputs through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SYNC_STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= {ser_in_i, frame_sync_i, bus_clk_i};
            for (int i = 1; i < SYNC_STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign dk_o  = stage_q[LAST][0];
    assign fs_o  = stage_q[LAST][1];
    assign din_o = stage_q[LAST][2];

    // Remember the previous synchronized levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dk_q <= 1'b0;
            fs_q <= 1'b0;
        end else begin
            dk_q <= dk_o;
            fs_q <= fs_o;
        end
    end

    assign rise_dk_o = dk_o & ~dk_q;
    assign fall_dk_o = ~dk_o & dk_q;
    assign rise_fs_o = fs_o & ~fs_q;
endmodule

// File: rtl/pcm_bslot_timer.sv
// Frame timer: finds the frame-start point, counts data-clock edges from
// it, checks that the sync spacing repeats (lock), and derives the channel
// window, the bit index and the receive sample strobes.
// Assumes edge strobes arrive from pcm_bslot_sync, at most one per cycle.
module pcm_bslot_timer
    import pcm_bslot_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int WORD_W = 8,
    parameter int IDX_W  = $clog2(WORD_W)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dk_i,
    input  logic             fs_i,
    input  logic             rise_dk_i,
    input  logic             fall_dk_i,
    input  logic             rise_fs_i,
    input  logic             slot_sel_i,
    output logic             start_ev_o,
    output logic             locked_o,
    output logic             chan_start_o,
    output logic             in_window_o,
    output logic [IDX_W-1:0] bit_idx_o,
    output logic             samp_ev_o,
    output logic             last_bit_o
);
    localparam int               CHAN_EDGES = WORD_W * EDGES_PER_BIT;
    localparam logic [CNT_W-1:0] CNT_MAX    = '1;
    localparam logic [CNT_W-1:0] CHAN_LEN   = CNT_W'(CHAN_EDGES);

    logic             pend_q;
    logic             locked_q;
    slot_e            slot_q;
    logic [CNT_W-1:0] hcnt_q;
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] hcnt_inc;
    logic [CNT_W-1:0] meas;
    logic [CNT_W-1:0] base;
    logic [CNT_W-1:0] pos_cur;
    logic [CNT_W-1:0] pos_nxt;
    logic             edge_ev;

    // Frame start: sync rise while clock high, or first rise after sync.
    assign start_ev_o = (rise_fs_i & dk_i) | (pend_q & rise_dk_i);
    assign edge_ev    = rise_dk_i | fall_dk_i;

    // Hold a sync rise seen during the low phase until the next rise.
    always_ff @(posedge clk) begin
        if (!rst_n)                      pend_q <= 1'b0;
        else if (start_ev_o | rise_dk_i) pend_q <= 1'b0;
        else if (rise_fs_i & ~dk_i)      pend_q <= 1'b1;
    end

    // Saturating increment and spacing measured at a frame start.
    always_comb begin
        hcnt_inc = (hcnt_q == CNT_MAX) ? hcnt_q : hcnt_q + 1'b1;
        meas     = rise_dk_i ? hcnt_inc : hcnt_q;
    end

    // Edge counter, restarted at every frame start.
    always_ff @(posedge clk) begin
        if (!rst_n)          hcnt_q <= CNT_MAX;
        else if (start_ev_o) hcnt_q <= '0;
        else if (edge_ev)    hcnt_q <= hcnt_inc;
    end

    // Channel select captured at frame start.
    always_ff @(posedge clk) begin
        if (!rst_n)          slot_q <= SLOT_B1;
        else if (start_ev_o) slot_q <= slot_e'(slot_sel_i);
    end

    // Spacing register and lock state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= CNT_MAX;
            locked_q <= 1'b0;
        end else if (start_ev_o) begin
            period_q <= meas;
            locked_q <= (meas == period_q) && (meas != CNT_MAX);
        end else if (fall_dk_i && (hcnt_q == '0) && !fs_i) begin
            locked_q <= 1'b0;
        end else if (edge_ev && (hcnt_inc > period_q)) begin
            locked_q <= 1'b0;
        end
    end

    assign locked_o = locked_q;

    // Position of the current and next edge inside the selected channel.
    always_comb begin
        base    = (slot_q == SLOT_B2) ? CHAN_LEN : '0;
        pos_cur = hcnt_q - base;
        pos_nxt = hcnt_inc - base;
    end

    // Channel window from MSB start up to the LSB's second falling edge.
    assign in_window_o = locked_q && (hcnt_q >= base) && (pos_cur < CHAN_LEN - 1'b1);
    assign bit_idx_o   = IDX_W'(pos_cur >> 2);

    // Transmit byte copy at the channel's first edge.
    assign chan_start_o = start_ev_o ? (slot_e'(slot_sel_i) == SLOT_B1)
                                     : (edge_ev && (slot_q == SLOT_B2)
                                        && (hcnt_q == CHAN_LEN - 1'b1));

    // Receive strobe at the second falling edge of each channel bit.
    assign samp_ev_o  = fall_dk_i && !start_ev_o && locked_q
                        && (hcnt_inc >= base) && (pos_nxt < CHAN_LEN)
                        && (pos_nxt[1:0] == 2'b11);
    assign last_bit_o = (pos_nxt == CHAN_LEN - 1'b1);
endmodule

// File: rtl/pcm_bslot_tx.sv
// Transmit path: holds the byte written by the host, copies it at the
// channel start and presents the selected bit with its drive enable.
// Assumes bit index and window come from pcm_bslot_timer.
module pcm_bslot_tx #(
    parameter int WORD_W = 8,
    parameter int IDX_W  = $clog2(WORD_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] tx_byte_i,
    input  logic              tx_load_i,
    input  logic              chan_start_i,
    input  logic              in_window_i,
    input  logic [IDX_W-1:0]  bit_idx_i,
    output logic              ser_out_o,
    output logic              ser_oe_o
);
    logic [WORD_W-1:0] hold_q;
    logic [WORD_W-1:0] lat_q;
    logic [IDX_W-1:0]  sel_idx;

    // Capture the host byte whenever it is strobed.
    always_ff @(posedge clk) begin
        if (!rst_n)         hold_q <= '0;
        else if (tx_load_i) hold_q <= tx_byte_i;
    end

    // Copy the byte for this channel, taking a same-cycle strobe directly.
    always_ff @(posedge clk) begin
        if (!rst_n)            lat_q <= '0;
        else if (chan_start_i) lat_q <= tx_load_i ? tx_byte_i : hold_q;
    end

    // MSB first: bit index 0 selects the top bit.
    assign sel_idx   = IDX_W'(WORD_W - 1) - bit_idx_i;
    assign ser_out_o = in_window_i ? lat_q[sel_idx] : 1'b0;
    assign ser_oe_o  = in_window_i;
endmodule

// File: rtl/pcm_bslot_rx.sv
// Receive path: shifts in one bit per sample strobe, MSB first, and
// presents the byte with a one-cycle valid pulse after the last bit.
// Assumes exactly WORD_W strobes per channel, the last one flagged.
module pcm_bslot_rx #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_ev_i,
    input  logic              last_bit_i,
    input  logic              din_i,
    output logic [WORD_W-1:0] rx_byte_o,
    output logic              rx_valid_o
);
    logic [WORD_W-2:0] shift_q;

    // Accumulate the incoming bits.
    always_ff @(posedge clk) begin
        if (!rst_n)         shift_q <= '0;
        else if (samp_ev_i) shift_q <= {shift_q[WORD_W-3:0], din_i};
    end

    // Deliver the byte and pulse valid on the last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_byte_o  <= '0;
            rx_valid_o <= 1'b0;
        end else begin
            rx_valid_o <= samp_ev_i & last_bit_i;
            if (samp_ev_i & last_bit_i) rx_byte_o <= {shift_q, din_i};
        end
    end
endmodule

// File: rtl/pcm_bslot_port.sv
// Top of the PCM B-channel serial port: synchronizer, frame timer,
// transmit and receive paths. Assumes clk is several times faster than
// the bus data clock; the bus output buffer is driven by ser_oe_o.
module pcm_bslot_port #(
    parameter int WORD_W      = 8,
    parameter int CNT_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_clk_i,
    input  logic              frame_sync_i,
    input  logic              ser_in_i,
    input  logic              slot_sel_i,
    input  logic [WORD_W-1:0] tx_byte_i,
    input  logic              tx_load_i,
    output logic              ser_out_o,
    output logic              ser_oe_o,
    output logic [WORD_W-1:0] rx_byte_o,
    output logic              rx_valid_o
);
    localparam int IDX_W = $clog2(WORD_W);

    logic             dk, fs, din_s;
    logic             rise_dk, fall_dk, rise_fs;
    logic             start_ev, locked, chan_start, in_window;
    logic             samp_ev, last_bit;
    logic [IDX_W-1:0] bit_idx;

    pcm_bslot_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_clk_i    (bus_clk_i),
        .frame_sync_i (frame_sync_i),
        .ser_in_i     (ser_in_i),
        .dk_o         (dk),
        .fs_o         (fs),
        .din_o        (din_s),
        .rise_dk_o    (rise_dk),
        .fall_dk_o    (fall_dk),
        .rise_fs_o    (rise_fs)
    );

    pcm_bslot_timer #(.CNT_W(CNT_W), .WORD_W(WORD_W), .IDX_W(IDX_W)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .dk_i         (dk),
        .fs_i         (fs),
        .rise_dk_i    (rise_dk),
        .fall_dk_i    (fall_dk),
        .rise_fs_i    (rise_fs),
        .slot_sel_i   (slot_sel_i),
        .start_ev_o   (start_ev),
        .locked_o     (locked),
        .chan_start_o (chan_start),
        .in_window_o  (in_window),
        .bit_idx_o    (bit_idx),
        .samp_ev_o    (samp_ev),
        .last_bit_o   (last_bit)
    );

    pcm_bslot_tx #(.WORD_W(WORD_W), .IDX_W(IDX_W)) u_tx (
        .clk          (clk),
        .rst_n        (rst_n),
        .tx_byte_i    (tx_byte_i),
        .tx_load_i    (tx_load_i),
        .chan_start_i (chan_start),
        .in_window_i  (in_window),
        .bit_idx_i    (bit_idx),
        .ser_out_o    (ser_out_o),
        .ser_oe_o     (ser_oe_o)
    );

    pcm_bslot_rx #(.WORD_W(WORD_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .samp_ev_i  (samp_ev),
        .last_bit_i (last_bit),
        .din_i      (din_s),
        .rx_byte_o  (rx_byte_o),
        .rx_valid_o (rx_valid_o)
    );
endmodule

// File: rtl/pcm_bslot_port_chk.sv
// Assertion checker for pcm_bslot_port, attached with bind below.
// Assumes the internal edge, start and lock strobes of the top.
module pcm_bslot_port_chk (
    input logic clk,
    input logic rst_n,
    input logic ser_out_o,
    input logic ser_oe_o,
    input logic rx_valid_o,
    input logic rise_dk,
    input logic fall_dk,
    input logic start_ev,
    input logic locked
);
    // R2: the enable only switches on at a clock rise or a frame start.
    a_r2_oe_on_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_oe_o) |-> $past(rise_dk || start_ev));

    // R3: while driven, the data bit moves only after a clock rise or restart.
    a_r3_data_moves_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_oe_o && $past(ser_oe_o) && !$past(rise_dk) && !$past(start_ev))
        |-> $stable(ser_out_o));

    // R4: the enable only switches off at a falling edge or a frame start.
    a_r4_oe_off_at_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_oe_o) |-> $past(fall_dk || start_ev));

    // R6: the valid pulse lasts one cycle.
    a_r6_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    // R9: with lock lost for two cycles the bus output stays released.
    a_r9_quiet_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && $past(!locked)) |-> !ser_oe_o);
endmodule

bind pcm_bslot_port pcm_bslot_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ser_out_o  (ser_out_o),
    .ser_oe_o   (ser_oe_o),
    .rx_valid_o (rx_valid_o),
    .rise_dk    (rise_dk),
    .fall_dk    (fall_dk),
    .start_ev   (start_ev),
    .locked     (locked)
);

// File: tb/tb_pcm_bslot_port.sv
`timescale 1ns/1ps
module tb_pcm_bslot_port;
    localparam int DH = 12;              // system cycles per data-clock half period

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_clk_i = 1'b0;
    logic       frame_sync_i = 1'b0;
    logic       ser_in_i = 1'b0;
    logic       slot_sel_i = 1'b0;
    logic [7:0] tx_byte_i = 8'h00;
    logic       tx_load_i = 1'b0;
    logic       ser_out_o, ser_oe_o, rx_valid_o;
    logic [7:0] rx_byte_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // bench model state
    int         since = 1000000;         // edges since last frame start
    int         plen  = -1;              // stored spacing, -1 = none
    logic [7:0] txhold = 8'h00;
    int         rx_cnt = 0;
    logic [7:0] rx_last = 8'h00;

    pcm_bslot_port dut (
        .clk(clk), .rst_n(rst_n), .bus_clk_i(bus_clk_i),
        .frame_sync_i(frame_sync_i), .ser_in_i(ser_in_i),
        .slot_sel_i(slot_sel_i), .tx_byte_i(tx_byte_i), .tx_load_i(tx_load_i),
        .ser_out_o(ser_out_o), .ser_oe_o(ser_oe_o),
        .rx_byte_o(rx_byte_o), .rx_valid_o(rx_valid_o)
    );

    always #10 clk = ~clk;               // 50 MHz

    // Count receive pulses away from the active edge.
    always @(negedge clk) begin
        if (rx_valid_o) begin
            rx_cnt  = rx_cnt + 1;
            rx_last = rx_byte_o;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected lock for a frame starting with a sync of the given mode.
    function automatic bit model_start(input int mode);
        bit lk;
        lk = (plen >= 0) && (since == plen);
        plen  = since;
        since = 0;
        if (mode == 2) lk = 1'b0;
        return lk;
    endfunction

    task automatic load_tx(input logic [7:0] b);
        @(negedge clk);
        tx_byte_i = b;
        tx_load_i = 1'b1;
        txhold    = b;
        @(negedge clk);
        tx_load_i = 1'b0;
    endtask

    // mode 0: sync rises with clock; 1: sync rises in high phase;
    // 2: sync too short; 3: sync missing.
    task automatic run_frame(input int p, input int mode, input logic [7:0] rxb,
                             input string tag, input string dtag);
        bit         lk;
        int         base;
        int         expoe, exprx;
        logic [7:0] txe;
        lk   = (mode == 3) ? 1'b0 : model_start(mode);
        base = slot_sel_i ? 32 : 0;
        txe  = txhold;
        rx_cnt = 0;
        for (int h = 0; h < 2 * p; h++) begin
            for (int s = 0; s < DH; s++) begin
                @(negedge clk);
                if (s == DH - 2 && !(mode == 2 && h == 0)) begin
                    expoe = (lk && h >= base && h <= base + 30) ? 1 : 0;
                    if (h == base && expoe == 1)       chk("R2", ser_oe_o, 1);
                    else if (h == base + 31)           chk(lk ? "R4" : tag, ser_oe_o, 0);
                    else if (expoe == 0)               chk(lk ? "R11" : tag, ser_oe_o, 0);
                    else                               chk("R3 oe", ser_oe_o, 1);
                    if (expoe == 1)
                        chk(dtag, ser_out_o, txe[7 - (h - base) / 4]);
                end
                if (s == 0) begin
                    bus_clk_i = ~h[0];
                    if (h >= base && h < base + 32) ser_in_i = rxb[7 - (h - base) / 4];
                    else                            ser_in_i = $urandom_range(0, 1);
                    if (h == 0 && (mode == 0 || mode == 2)) frame_sync_i = 1'b1;
                    if (h == 2) frame_sync_i = 1'b0;
                end
                if (s == 3 && h == 0 && mode == 1) frame_sync_i = 1'b1;
                if (s == 6 && h == 0 && mode == 2) frame_sync_i = 1'b0;
            end
        end
        since = since + 2 * p;
        exprx = (lk && base + 31 < 2 * p) ? 1 : 0;
        chk(exprx == 1 ? "R6 count" : tag, rx_cnt, exprx);
        if (exprx == 1 && rx_cnt == 1) chk("R6 byte", rx_last, rxb);
    endtask

    // Watchdog: a hung run is a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 oe", ser_oe_o, 0);
        chk("R1 valid", rx_valid_o, 0);

        // Acquire lock in B1 (first two frames exchange nothing).
        slot_sel_i = 1'b0;
        load_tx(8'hA5);
        run_frame(64, 0, 8'h5A, "R8", "R3");
        run_frame(64, 0, 8'h5A, "R8", "R3");
        run_frame(64, 0, 8'hC3, "R8", "R3");
        // Resend without load, sync rising inside the high phase.
        run_frame(64, 1, 8'h81, "R8", "R7");
        // Second channel.
        slot_sel_i = 1'b1;
        load_tx(8'h3C);
        run_frame(64, 0, 8'h7E, "R8", "R5");
        run_frame(64, 1, 8'h01, "R8", "R5");
        // Sync too short: frame abandoned.
        load_tx(8'hF0);
        run_frame(64, 2, 8'h99, "R10", "R5");
        run_frame(64, 0, 8'h66, "R9", "R5");
        // Missing sync and recovery.
        slot_sel_i = 1'b0;
        run_frame(64, 3, 8'h11, "R9", "R3");
        run_frame(64, 0, 8'h22, "R9", "R3");
        run_frame(64, 0, 8'h33, "R9", "R3");
        run_frame(64, 0, 8'h44, "R9", "R3");
        // Early sync: short frame, then recovery.
        run_frame(40, 0, 8'h55, "R9", "R3");
        run_frame(64, 0, 8'h12, "R9", "R3");
        run_frame(64, 0, 8'h34, "R9", "R3");
        run_frame(64, 0, 8'h56, "R9", "R3");

        // Random frames.
        for (int i = 0; i < 22; i++) begin
            int p;
            slot_sel_i = $urandom_range(0, 1);
            if ($urandom_range(0, 9) < 7) load_tx(8'($urandom));
            p = ($urandom_range(0, 7) == 0) ? 72 : 64;
            run_frame(p, $urandom_range(0, 1), 8'($urandom), "R9",
                      slot_sel_i ? "R5" : "R3");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule